// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block sequences the low-power modes of a small microcontroller core. A single-cycle halt request from the CPU puts the block into one of two sleep flavours, chosen by the oscillator interrupt enable input. With the enable set, the block enters active-halt: the main oscillator and the time-base counter keep running, so a periodic interrupt can wake the core. With the enable clear, the block enters a deep halt in which every clock enable is dropped. In both flavours the CPU interrupt mask is forced to the value that lets interrupts through, so a request that is already pending wakes the core at once.

Wake-up behaviour depends on both the flavour and the source. An interrupt that wakes active-halt restarts the CPU clock on the next cycle with no delay. A reset wake, and any wake from deep halt, first runs the oscillator through a stabilisation delay of 256 or 4096 cycles, selected by a static configuration input, and then signals either a reset-vector fetch or an interrupt service. After a time-base wake, the block watches the interrupt enable for one delay period. If software clears the enable inside that window, the block falls into deep halt until the window has run out. A watchdog reset request is raised when deep halt is entered with the watchdog active, and never for active-halt.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `mode` is 00 (run), all four clock enables are 1, `mask_force` is 0, and `irq_service`, `fetch_vec` and `wdg_rst_req` are 0.
- R2: A `halt_req` pulse in run with `osc_irq_en`=1 gives `mode`=01 (active-halt) on the next cycle, with `osc_clk_en`=1, `tb_clk_en`=1, `cpu_clk_en`=0 and `periph_clk_en`=0.
- R3: A `halt_req` pulse in run with `osc_irq_en`=0 gives `mode`=10 (halt) on the next cycle with all four clock enables at 0.
- R4: In every halt mode (`mode` 01 or 10) `mask_force` is 1 and `mask_val` is binary 10; in run `mask_force` is 0.
- R5: In active-halt, `ext_irq` or `tb_irq` returns the block to `mode`=00 on the next cycle with a one-cycle `irq_service` pulse in that same cycle; an interrupt already high when the halt request is taken wakes the block after a single active-halt cycle.
- R6: `wake_rst` in any halt mode gives `mode`=11 (delay) for exactly N cycles, with only `osc_clk_en` set, where N is 256 when `long_dly_sel`=0 and 4096 when it is 1; the block then returns to `mode`=00 with a one-cycle `fetch_vec` pulse.
- R7: In halt entered from run, `tb_irq` is ignored, and `ext_irq` leads to the N-cycle delay of R6 followed by `mode`=00 with a one-cycle `irq_service` pulse.
- R8: If `osc_irq_en` is cleared in run within N cycles of a `tb_irq` wake from active-halt, `mode` becomes 10 on the next cycle and stays there until N cycles after the wake, then returns to 00; clearing it after that window has no effect.
- R9: `wdg_rst_req` pulses for one cycle, together with entry into halt, when the halt request is taken with `osc_irq_en`=0 and `wdg_active`=1; entering active-halt never raises it.
- R10: `halt_req` is ignored in every mode other than run.
- R11: When `wake_rst` and an interrupt arrive together in active-halt, the reset wins: the block goes to `mode`=11 and raises no `irq_service` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset to run |
| halt_req | input | 1 | One-cycle halt request from the CPU |
| osc_irq_en | input | 1 | Oscillator interrupt enable; selects active-halt (1) or halt (0) |
| wdg_active | input | 1 | Watchdog is running |
| long_dly_sel | input | 1 | Static: 0 selects the short delay, 1 the long delay |
| ext_irq | input | 1 | External interrupt wake |
| tb_irq | input | 1 | Time-base interrupt wake |
| wake_rst | input | 1 | Reset wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_clk_en | output | 1 | Main oscillator enable |
| tb_clk_en | output | 1 | Time-base counter clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| mask_force | output | 1 | Interrupt mask override active |
| mask_val | output | 2 | Value forced onto the interrupt mask bits |
| irq_service | output | 1 | One-cycle pulse: resume by servicing the interrupt |
| fetch_vec | output | 1 | One-cycle pulse: resume by fetching the reset vector |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| mode | output | 2 | Current mode: 00 run, 01 active-halt, 10 halt, 11 delay |

## Verification
The bench measures the delay length in cycles for both settings of the delay select and for both reset and external wakes, so an off-by-one counter or a swapped select shows up as a wrong count. It enters active-halt with an interrupt already pending, which catches a design that waits for an edge or never applies the forced mask. It clears the interrupt enable inside and after the guard window following a time-base wake, catching a design that ignores the window, measures it from the wrong cycle or never lets it expire. It also presents a reset and an interrupt together, a time-base interrupt during deep halt and a halt request while asleep, where a wrong priority or a missing guard would wake the core early or with the wrong indication.

// File: rtl/phc_pkg.sv
package phc_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_AHALT = 3'd1,
    ST_HALT  = 3'd2,
    ST_DELAY = 3'd3,
    ST_GHALT = 3'd4
  } phc_state_e;

  typedef struct packed {
    logic cpu;
    logic osc;
    logic tb;
    logic per;
  } phc_clk_t;

  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_AHALT = 2'b01;
  localparam logic [1:0] MODE_HALT  = 2'b10;
  localparam logic [1:0] MODE_DELAY = 2'b11;

  localparam logic [1:0] MASK_ON_HALT = 2'b10;

  // Stabilisation length in cycles for a given select value.
  function automatic int unsigned wake_delay(input logic long_sel,
                                             input int unsigned short_n,
                                             input int unsigned long_n);
    return long_sel ? long_n : short_n;
  endfunction

  // Two-bit status code seen at the boundary for each internal state.
  function automatic logic [1:0] mode_of(input phc_state_e s);
    case (s)
      ST_RUN:   return MODE_RUN;
      ST_AHALT: return MODE_AHALT;
      ST_DELAY: return MODE_DELAY;
      default:  return MODE_HALT;
    endcase
  endfunction

endpackage

// File: rtl/phc_downcnt.sv
module phc_downcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] value,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign value = cnt_q;
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/phc_clkmap.sv
module phc_clkmap
  import phc_pkg::*;
(
  input  phc_state_e state,
  output phc_clk_t   clk_en,
  output logic [1:0] mode,
  output logic       mask_force
);

  always_comb begin
    clk_en = '{cpu: 1'b0, osc: 1'b0, tb: 1'b0, per: 1'b0};
    case (state)
      ST_RUN:   clk_en = '{cpu: 1'b1, osc: 1'b1, tb: 1'b1, per: 1'b1};
      ST_AHALT: clk_en = '{cpu: 1'b0, osc: 1'b1, tb: 1'b1, per: 1'b0};
      ST_DELAY: clk_en = '{cpu: 1'b0, osc: 1'b1, tb: 1'b0, per: 1'b0};
      default:  clk_en = '{cpu: 1'b0, osc: 1'b0, tb: 1'b0, per: 1'b0};
    endcase
  end

  assign mode       = mode_of(state);
  assign mask_force = (state == ST_AHALT) || (state == ST_HALT) || (state == ST_GHALT);

endmodule

// File: rtl/pwr_halt_ctrl.sv
module pwr_halt_ctrl
  import phc_pkg::*;
#(
  parameter int unsigned SHORT_DLY = 256,
  parameter int unsigned LONG_DLY  = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  logic       osc_irq_en,
  input  logic       wdg_active,
  input  logic       long_dly_sel,
  input  logic       ext_irq,
  input  logic       tb_irq,
  input  logic       wake_rst,
  output logic       cpu_clk_en,
  output logic       osc_clk_en,
  output logic       tb_clk_en,
  output logic       periph_clk_en,
  output logic       mask_force,
  output logic [1:0] mask_val,
  output logic       irq_service,
  output logic       fetch_vec,
  output logic       wdg_rst_req,
  output logic [1:0] mode
);

  localparam int CNT_W = $clog2(LONG_DLY);

  phc_state_e state_q, state_d;
  logic       dly_is_rst_q;
  logic       guard_on_q;
  logic       irq_q, fetch_q, wdg_q;

  logic [CNT_W-1:0] dly_last;
  logic [CNT_W-1:0] d_val, g_val;
  logic             d_zero, g_zero;

  // Named events, also observed by the checker.
  logic hreq_ok, guard_drop, ah_irq_wake, tb_only_wake;
  logic rst_wake, halt_irq_wake, dly_start, dly_done, guard_end;

  assign dly_last = CNT_W'(wake_delay(long_dly_sel, SHORT_DLY, LONG_DLY) - 1);

  assign guard_drop    = (state_q == ST_RUN) && guard_on_q && !g_zero && !osc_irq_en;
  assign hreq_ok       = (state_q == ST_RUN) && halt_req && !guard_drop;
  assign ah_irq_wake   = (state_q == ST_AHALT) && !wake_rst && (ext_irq || tb_irq);
  assign tb_only_wake  = ah_irq_wake && !ext_irq;
  assign rst_wake      = wake_rst && ((state_q == ST_AHALT) || (state_q == ST_HALT) ||
                                      (state_q == ST_GHALT));
  assign halt_irq_wake = (state_q == ST_HALT) && !wake_rst && ext_irq;
  assign dly_start     = rst_wake || halt_irq_wake;
  assign dly_done      = (state_q == ST_DELAY) && d_zero;
  assign guard_end     = guard_on_q && g_zero;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (guard_drop)   state_d = ST_GHALT;
        else if (hreq_ok) state_d = osc_irq_en ? ST_AHALT : ST_HALT;
      end
      ST_AHALT: begin
        if (rst_wake)         state_d = ST_DELAY;
        else if (ah_irq_wake) state_d = ST_RUN;
      end
      ST_HALT: begin
        if (dly_start) state_d = ST_DELAY;
      end
      ST_DELAY: begin
        if (d_zero) state_d = ST_RUN;
      end
      ST_GHALT: begin
        if (rst_wake)       state_d = ST_DELAY;
        else if (guard_end) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      dly_is_rst_q <= 1'b0;
      guard_on_q   <= 1'b0;
      irq_q        <= 1'b0;
      fetch_q      <= 1'b0;
      wdg_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (dly_start) dly_is_rst_q <= rst_wake;
      if (tb_only_wake)                          guard_on_q <= 1'b1;
      else if (hreq_ok || rst_wake || guard_end) guard_on_q <= 1'b0;
      irq_q   <= ah_irq_wake || (dly_done && !dly_is_rst_q);
      fetch_q <= dly_done && dly_is_rst_q;
      wdg_q   <= hreq_ok && !osc_irq_en && wdg_active;
    end
  end

  phc_downcnt #(.W(CNT_W)) u_dly_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_start),
    .load_val (dly_last),
    .run      (state_q == ST_DELAY),
    .value    (d_val),
    .zero     (d_zero)
  );

  phc_downcnt #(.W(CNT_W)) u_guard_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (tb_only_wake),
    .load_val (dly_last),
    .run      (guard_on_q),
    .value    (g_val),
    .zero     (g_zero)
  );

  phc_clk_t clk_en;

  phc_clkmap u_map (
    .state      (state_q),
    .clk_en     (clk_en),
    .mode       (mode),
    .mask_force (mask_force)
  );

  assign cpu_clk_en    = clk_en.cpu;
  assign osc_clk_en    = clk_en.osc;
  assign tb_clk_en     = clk_en.tb;
  assign periph_clk_en = clk_en.per;
  assign mask_val      = MASK_ON_HALT;
  assign irq_service   = irq_q;
  assign fetch_vec     = fetch_q;
  assign wdg_rst_req   = wdg_q;

  logic unused_cnt;
  assign unused_cnt = ^{d_val, g_val};

endmodule

// File: rtl/phc_checker.sv
module phc_checker
  import phc_pkg::*;
#(
  parameter int unsigned SHORT_DLY = 256,
  parameter int unsigned LONG_DLY  = 4096
) (
  input logic       clk,
  input logic       rst,
  input logic       halt_req,
  input logic       long_dly_sel,
  input logic       ext_irq,
  input logic       tb_irq,
  input logic       wake_rst,
  input logic       cpu_clk_en,
  input logic       osc_clk_en,
  input logic       tb_clk_en,
  input logic       periph_clk_en,
  input logic       mask_force,
  input logic [1:0] mask_val,
  input logic       irq_service,
  input logic       fetch_vec,
  input logic       wdg_rst_req,
  input logic [1:0] mode
);

  localparam int CW = $clog2(LONG_DLY) + 1;

  logic [CW-1:0] run_len, exp_len;
  assign exp_len = CW'(wake_delay(long_dly_sel, SHORT_DLY, LONG_DLY));

  always_ff @(posedge clk) begin
    if (rst || (mode != MODE_DELAY)) run_len <= '0;
    else                             run_len <= run_len + 1'b1;
  end

  p_ahalt_clocks_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_AHALT) |-> (osc_clk_en && tb_clk_en && !cpu_clk_en && !periph_clk_en));

  p_halt_clocks_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALT) |-> !(osc_clk_en || tb_clk_en || cpu_clk_en || periph_clk_en));

  p_mask_forced_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_AHALT) || (mode == MODE_HALT)) |-> (mask_force && (mask_val == 2'b10)));

  p_run_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN) |-> !mask_force);

  p_irq_wake_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_AHALT) && !wake_rst && (ext_irq || tb_irq)) |=>
      ((mode == MODE_RUN) && irq_service));

  p_rst_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (((mode == MODE_AHALT) || (mode == MODE_HALT)) && wake_rst) |=> (mode == MODE_DELAY));

  p_delay_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DELAY) |-> (run_len < exp_len));

  p_delay_exit_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_RUN) && ($past(mode) == MODE_DELAY)) |-> (run_len == exp_len));

  p_fetch_after_delay_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_vec |-> ((mode == MODE_RUN) && ($past(mode) == MODE_DELAY) && !irq_service));

  p_wdg_halt_only_r9: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_req |-> (mode == MODE_HALT));

  p_hreq_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_AHALT) && halt_req && !ext_irq && !tb_irq && !wake_rst) |=>
      (mode == MODE_AHALT));

  p_rst_priority_r11: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_AHALT) && wake_rst && (ext_irq || tb_irq)) |=>
      ((mode == MODE_DELAY) && !irq_service));

endmodule

bind pwr_halt_ctrl phc_checker #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .halt_req      (halt_req),
  .long_dly_sel  (long_dly_sel),
  .ext_irq       (ext_irq),
  .tb_irq        (tb_irq),
  .wake_rst      (wake_rst),
  .cpu_clk_en    (cpu_clk_en),
  .osc_clk_en    (osc_clk_en),
  .tb_clk_en     (tb_clk_en),
  .periph_clk_en (periph_clk_en),
  .mask_force    (mask_force),
  .mask_val      (mask_val),
  .irq_service   (irq_service),
  .fetch_vec     (fetch_vec),
  .wdg_rst_req   (wdg_rst_req),
  .mode          (mode)
);

// File: tb/pwr_halt_ctrl_test.sv
module pwr_halt_ctrl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 1'b0, osc_irq_en = 1'b1, wdg_active = 1'b0, long_dly_sel = 1'b0;
  logic ext_irq = 1'b0, tb_irq = 1'b0, wake_rst = 1'b0;
  logic cpu_clk_en, osc_clk_en, tb_clk_en, periph_clk_en, mask_force;
  logic [1:0] mask_val, mode;
  logic irq_service, fetch_vec, wdg_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_halt_ctrl uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .wdg_active(wdg_active), .long_dly_sel(long_dly_sel), .ext_irq(ext_irq),
    .tb_irq(tb_irq), .wake_rst(wake_rst), .cpu_clk_en(cpu_clk_en),
    .osc_clk_en(osc_clk_en), .tb_clk_en(tb_clk_en), .periph_clk_en(periph_clk_en),
    .mask_force(mask_force), .mask_val(mask_val), .irq_service(irq_service),
    .fetch_vec(fetch_vec), .wdg_rst_req(wdg_rst_req), .mode(mode)
  );

  // Stimulus table: [5] enable, [4:3] wake source (0 ext, 1 time base, 2 reset),
  // [2] delay select, [1:0] expected sleep mode.
  localparam int NV = 7;
  localparam logic [5:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 2'b01},
    {1'b1, 2'd1, 1'b0, 2'b01},
    {1'b1, 2'd2, 1'b0, 2'b01},
    {1'b0, 2'd0, 1'b0, 2'b10},
    {1'b0, 2'd2, 1'b1, 2'b10},
    {1'b1, 2'd2, 1'b1, 2'b01},
    {1'b0, 2'd0, 1'b1, 2'b10}
  };

  function automatic int dly_cycles(input logic sel);
    return sel ? 4096 : 256;
  endfunction

  function automatic logic [3:0] exp_clocks(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b1111;
      2'b01:   return 4'b0110;
      2'b11:   return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [3:0] clocks_now();
    return {cpu_clk_en, osc_clk_en, tb_clk_en, periph_clk_en};
  endfunction

  // Count cycles spent in delay, then check the resume indication.
  task automatic finish_delay(input int n, input bit want_fetch, input string req);
    int seen = 0;
    while (mode == 2'b11 && seen < 5000) begin
      if (seen == 0) chk(clocks_now() == exp_clocks(2'b11), req, clocks_now(), exp_clocks(2'b11));
      seen++;
      step();
    end
    chk(seen == n, req, seen, n);
    chk(mode == 2'b00, req, mode, 0);
    chk(fetch_vec == want_fetch && irq_service == !want_fetch, req,
        {fetch_vec, irq_service}, {want_fetch, !want_fetch});
    step();
    chk(!fetch_vec && !irq_service, req, {fetch_vec, irq_service}, 0);
  endtask

  task automatic enter_halt(input logic en);
    osc_irq_en = en;
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1: reset state
    chk(mode == 2'b00 && clocks_now() == 4'b1111 && !mask_force, "R1", {mode, clocks_now()}, 6'b001111);
    rst = 1'b0;
    step();
    chk(mode == 2'b00 && clocks_now() == 4'b1111 && !irq_service && !fetch_vec && !wdg_rst_req,
        "R1", {mode, clocks_now()}, 6'b001111);

    // Table walk: R2, R3, R4, R5, R6, R7
    for (int i = 0; i < NV; i++) begin
      logic en = VEC[i][5];
      logic [1:0] src = VEC[i][4:3];
      logic sel = VEC[i][2];
      logic [1:0] em = VEC[i][1:0];
      bit delayed = (src == 2'd2) || !en;
      long_dly_sel = sel;
      enter_halt(en);
      chk(mode == em, en ? "R2" : "R3", mode, em);
      chk(clocks_now() == exp_clocks(em), en ? "R2" : "R3", clocks_now(), exp_clocks(em));
      chk(mask_force && mask_val == 2'b10, "R4", {mask_force, mask_val}, 3'b110);
      ext_irq = (src == 2'd0);
      tb_irq = (src == 2'd1);
      wake_rst = (src == 2'd2);
      step();
      ext_irq = 1'b0; tb_irq = 1'b0; wake_rst = 1'b0;
      if (!delayed) begin
        chk(mode == 2'b00 && irq_service && !fetch_vec, "R5", {mode, irq_service}, 3'b001);
        chk(!mask_force && clocks_now() == 4'b1111, "R4", {mask_force, clocks_now()}, 5'b01111);
        step();
        chk(!irq_service, "R5", irq_service, 0);
      end else begin
        finish_delay(dly_cycles(sel), src == 2'd2, (src == 2'd2) ? "R6" : "R7");
      end
    end

    // R5: interrupt pending when the halt request is taken
    long_dly_sel = 1'b0;
    ext_irq = 1'b1;
    enter_halt(1'b1);
    chk(mode == 2'b01, "R5", mode, 1);
    step();
    ext_irq = 1'b0;
    chk(mode == 2'b00 && irq_service, "R5", {mode, irq_service}, 3'b001);
    step();

    // R7: time-base interrupt ignored in halt
    enter_halt(1'b0);
    tb_irq = 1'b1;
    step(); step(); step();
    tb_irq = 1'b0;
    chk(mode == 2'b10 && !irq_service, "R7", {mode, irq_service}, 3'b100);
    wake_rst = 1'b1; step(); wake_rst = 1'b0;
    finish_delay(256, 1'b1, "R6");

    // R10: halt request ignored while asleep
    enter_halt(1'b1);
    halt_req = 1'b1; step(); halt_req = 1'b0;
    chk(mode == 2'b01, "R10", mode, 1);
    step();
    chk(mode == 2'b01, "R10", mode, 1);
    ext_irq = 1'b1; step(); ext_irq = 1'b0;
    step();

    // R9: watchdog request for halt only
    wdg_active = 1'b1;
    enter_halt(1'b0);
    chk(wdg_rst_req && mode == 2'b10, "R9", {wdg_rst_req, mode}, 3'b110);
    step();
    chk(!wdg_rst_req, "R9", wdg_rst_req, 0);
    wake_rst = 1'b1; step(); wake_rst = 1'b0;
    finish_delay(256, 1'b1, "R6");
    enter_halt(1'b1);
    chk(!wdg_rst_req && mode == 2'b01, "R9", {wdg_rst_req, mode}, 3'b001);
    tb_irq = 1'b1; step(); tb_irq = 1'b0;
    wdg_active = 1'b0;
    // Guard window from the wake just made: let it lapse with enable set.
    repeat (300) step();
    osc_irq_en = 1'b0;
    step(); step(); step();
    chk(mode == 2'b00, "R8", mode, 0);
    osc_irq_en = 1'b1;
    step();

    // R8: enable cleared inside the guard window
    begin
      int cnt;
      enter_halt(1'b1);
      tb_irq = 1'b1; step(); tb_irq = 1'b0;
      cnt = 1;
      chk(mode == 2'b00 && irq_service, "R8", {mode, irq_service}, 3'b001);
      repeat (9) begin step(); cnt++; end
      osc_irq_en = 1'b0;
      step(); cnt++;
      chk(mode == 2'b10 && clocks_now() == 4'b0000, "R8", {mode, clocks_now()}, 6'b100000);
      while (mode == 2'b10 && cnt < 5000) begin step(); cnt++; end
      chk(cnt == 257, "R8", cnt, 257);
      chk(mode == 2'b00, "R8", mode, 0);
      osc_irq_en = 1'b1;
      step();
    end

    // R11: reset wins over a simultaneous interrupt
    enter_halt(1'b1);
    ext_irq = 1'b1; wake_rst = 1'b1;
    step();
    ext_irq = 1'b0; wake_rst = 1'b0;
    chk(mode == 2'b11 && !irq_service, "R11", {mode, irq_service}, 3'b110);
    finish_delay(256, 1'b1, "R11");

    // R1: synchronous reset out of halt
    enter_halt(1'b0);
    rst = 1'b1; step(); rst = 1'b0; step();
    chk(mode == 2'b00 && clocks_now() == 4'b1111 && !mask_force, "R1", {mode, clocks_now()}, 6'b001111);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule